// File: doc/BRIEF.md
# Dual-Strobe Reversible Decade/Binary Counter

This block is a small reversible counter whose value moves up by one on each rising edge of an up strobe and down by one on each rising edge of a separate down strobe. A build-time parameter selects the sequence. In decade mode the count runs 0 to 9. In binary mode it covers the full width of the count. An active-low load copies a preset word into the count. An active-high clear forces the count to zero and wins over every other input.

All four strobes are sampled on one system clock. Each passes through a two-stage synchronizer and is then edge-detected. Because of this, the strobes can come from slow, unrelated sources such as switches, another clock domain or the outputs of a lower stage.

Two active-low terminal outputs repeat the low phase of the active strobe while the count sits at its end of range. The carry output is low while the count is at the top value and the up strobe is low. The borrow output is low while the count is zero and the down strobe is low. Each output returns high as that strobe rises. Feeding the carry and borrow of one stage into the up and down strobes of the next gives a multi-digit counter with no extra gates.

Top module: `udc_counter`

## Requirements
- R1: A strobe level applied before system clock edge k reaches the count logic after edge k+1. When up_clk_i goes from 0 to 1 at that point, with clear high, load low and no down rise at the same time, count_o increments and shows the new value after edge k+2.
- R2: A 0-to-1 transition of dn_clk_i, timed the same way as in R1, decrements count_o by one.
- R3: The top value is 9 when DECADE=1 and 2**WIDTH-1 when DECADE=0. Counting up from the top value gives 0. Counting down from 0 gives the top value.
- R4: While clear_i is 1, count_o becomes 0 two edges after clear_i is applied. This overrides the load and both strobes.
- R5: While load_n_i is 0 and clear_i is 0, count_o takes preset_i one edge after the synchronized load is seen, and strobe edges have no effect.
- R6: carry_n_o is 0 exactly when count_o equals the top value and the synchronized up strobe (up_clk_i as applied two edges earlier) is 0. Otherwise it is 1.
- R7: borrow_n_o is 0 exactly when count_o is 0 and the synchronized down strobe is 0. Otherwise it is 1.
- R8: After system reset, count_o is 0 and both terminal outputs are 1. With no strobe edge, load or clear, the count holds.
- R9: A strobe held low through a load or clear and raised after the release is counted as one event.
- R10: If up and down rising edges are recognised on the same system cycle, the count holds.
- R11: In decade mode a preset of 10 to 15 is loaded unchanged. Counting up from such a value gives 0, and counting down decrements it by one.
- R12: Two instances chained carry-to-up and borrow-to-down count as a two-digit decade counter, both upward and downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low system reset |
| up_clk_i | input | 1 | Count-up strobe; rising edge adds one; idles high |
| dn_clk_i | input | 1 | Count-down strobe; rising edge subtracts one; idles high |
| load_n_i | input | 1 | Active-low preset load |
| clear_i | input | 1 | Active-high clear, highest priority |
| preset_i | input | WIDTH | Value copied into the count during a load |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low terminal count for counting up |
| borrow_n_o | output | 1 | Active-low terminal count for counting down |

## Verification
A wrong stored count shows up directly on count_o after the edge that updates it. It also shows up on a terminal output whenever the strobe that guards that output is low. A wrong synchronizer or edge-detector state either drops a count or adds one. That error appears two system edges after the strobe change, so the bench compares all three outputs against its model on every cycle. In a cascade, a bad terminal output corrupts the upper digit about five edges later, so the two-digit checks are made only after that delay.

// File: rtl/udc_pkg.sv
package udc_pkg;

  // Operation chosen for the count register on a given system cycle
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CLEAR,
    OP_LOAD,
    OP_INC,
    OP_DEC
  } cnt_op_e;

  // Bundle of the four asynchronous control strobes
  typedef struct packed {
    logic clear;
    logic load_n;
    logic dn;
    logic up;
  } strobe_t;

  // Idle values: clear inactive, load inactive, both count strobes high
  localparam strobe_t STROBE_IDLE = '{clear: 1'b0, load_n: 1'b1, dn: 1'b1, up: 1'b1};

  // Highest value of the count sequence
  function automatic int unsigned term_max(input bit decade, input int unsigned width);
    if (decade) begin
      return 32'd9;
    end
    return (32'd1 << width) - 32'd1;
  endfunction

endpackage

// File: rtl/udc_sync.sv
// Multi-stage level synchronizer for a bundle of asynchronous inputs
module udc_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg[i] <= RST_VAL;
      end
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/udc_edge.sv
// Rising-edge detector on synchronized strobe levels
module udc_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '1;
    end else begin
      prev <= lvl;
    end
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/udc_core.sv
// Count register with priority decode of clear, load and strobe edges
module udc_core
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned MAXV  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_n,
  input  logic             up_rise,
  input  logic             dn_rise,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] MAX_C = WIDTH'(MAXV);
  localparam logic [WIDTH-1:0] ONE_C = WIDTH'(1);

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;

  always_comb begin
    if (clear) begin
      op = OP_CLEAR;
    end else if (!load_n) begin
      op = OP_LOAD;
    end else if (up_rise && !dn_rise) begin
      op = OP_INC;
    end else if (dn_rise && !up_rise) begin
      op = OP_DEC;
    end else begin
      op = OP_HOLD;
    end
  end

  always_comb begin
    case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = preset;
      OP_INC:   nxt = (count >= MAX_C) ? '0 : count + ONE_C;
      OP_DEC:   nxt = (count == '0) ? MAX_C : count - ONE_C;
      default:  nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= nxt;
    end
  end
endmodule

// File: rtl/udc_term.sv
// Terminal-count outputs that repeat the low phase of the active strobe
module udc_term #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned MAXV  = 9
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] MAX_C = WIDTH'(MAXV);

  logic at_top;
  logic at_zero;

  assign at_top   = (count == MAX_C);
  assign at_zero  = (count == '0);
  assign carry_n  = ~(at_top & ~up_lvl);
  assign borrow_n = ~(at_zero & ~dn_lvl);
endmodule

// File: rtl/udc_counter.sv
// Dual-strobe presettable reversible counter, decade or binary sequence
module udc_counter
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter bit          DECADE      = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_clk_i,
  input  logic             dn_clk_i,
  input  logic             load_n_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam int unsigned MAXV = term_max(DECADE, WIDTH);

  strobe_t    raw_s;
  strobe_t    syn_s;
  logic       clr_s;
  logic       ld_n_s;
  logic       up_s;
  logic       dn_s;
  logic [1:0] rise_v;
  logic       up_rise;
  logic       dn_rise;

  assign raw_s = '{clear: clear_i, load_n: load_n_i, dn: dn_clk_i, up: up_clk_i};

  udc_sync #(
    .W      ($bits(strobe_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(STROBE_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_s),
    .q    (syn_s)
  );

  assign clr_s  = syn_s.clear;
  assign ld_n_s = syn_s.load_n;
  assign up_s   = syn_s.up;
  assign dn_s   = syn_s.dn;

  udc_edge #(
    .W(2)
  ) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({dn_s, up_s}),
    .rise (rise_v)
  );

  assign up_rise = rise_v[0];
  assign dn_rise = rise_v[1];

  udc_core #(
    .WIDTH(WIDTH),
    .MAXV (MAXV)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clr_s),
    .load_n (ld_n_s),
    .up_rise(up_rise),
    .dn_rise(dn_rise),
    .preset (preset_i),
    .count  (count_o)
  );

  udc_term #(
    .WIDTH(WIDTH),
    .MAXV (MAXV)
  ) u_term (
    .count   (count_o),
    .up_lvl  (up_s),
    .dn_lvl  (dn_s),
    .carry_n (carry_n_o),
    .borrow_n(borrow_n_o)
  );
endmodule

// File: rtl/udc_counter_chk.sv
// Property checker for udc_counter, attached by bind
module udc_counter_chk #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned MAXV  = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_s,
  input logic             ld_n_s,
  input logic             up_rise,
  input logic             dn_rise,
  input logic [WIDTH-1:0] preset_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o,
  input logic             borrow_n_o
);
  localparam logic [WIDTH-1:0] MAX_C = WIDTH'(MAXV);
  localparam logic [WIDTH-1:0] ONE_C = WIDTH'(1);

  logic counting;
  assign counting = !clr_s && ld_n_s;

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && up_rise && !dn_rise && count_o < MAX_C) |=> count_o == $past(count_o) + ONE_C);

  // R2
  dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && dn_rise && !up_rise && count_o != '0) |=> count_o == $past(count_o) - ONE_C);

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && up_rise && !dn_rise && count_o >= MAX_C) |=> count_o == '0);

  // R3
  dn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && dn_rise && !up_rise && count_o == '0) |=> count_o == MAX_C);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> count_o == '0);

  // R5
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !ld_n_s) |=> count_o == $past(preset_i));

  // R6
  carry_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |-> count_o == MAX_C);

  // R7
  borrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n_o |-> count_o == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !up_rise && !dn_rise) |=> $stable(count_o));

  // R10
  both_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && up_rise && dn_rise) |=> $stable(count_o));
endmodule

bind udc_counter udc_counter_chk #(
  .WIDTH(WIDTH),
  .MAXV (MAXV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_s     (clr_s),
  .ld_n_s    (ld_n_s),
  .up_rise   (up_rise),
  .dn_rise   (dn_rise),
  .preset_i  (preset_i),
  .count_o   (count_o),
  .carry_n_o (carry_n_o),
  .borrow_n_o(borrow_n_o)
);

// File: tb/tb_udc_counter.sv
module tb_udc_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       up = 1'b1, dn = 1'b1, ld_n = 1'b1, clr = 1'b0;
  logic [3:0] pre = 4'd0;
  logic [3:0] hi_pre = 4'd0;

  logic [3:0] cnt_d, cnt_b, cnt_h;
  logic       cy_d, bw_d, cy_b, bw_b, cy_h, bw_h;

  udc_counter #(.WIDTH(4), .DECADE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .up_clk_i(up), .dn_clk_i(dn), .load_n_i(ld_n),
    .clear_i(clr), .preset_i(pre), .count_o(cnt_d), .carry_n_o(cy_d), .borrow_n_o(bw_d));

  udc_counter #(.WIDTH(4), .DECADE(1'b0)) dut_bin (
    .clk(clk), .rst_n(rst_n), .up_clk_i(up), .dn_clk_i(dn), .load_n_i(ld_n),
    .clear_i(clr), .preset_i(pre), .count_o(cnt_b), .carry_n_o(cy_b), .borrow_n_o(bw_b));

  // Upper digit of a two-stage cascade (R12)
  udc_counter #(.WIDTH(4), .DECADE(1'b1)) dut_hi (
    .clk(clk), .rst_n(rst_n), .up_clk_i(cy_d), .dn_clk_i(bw_d), .load_n_i(ld_n),
    .clear_i(clr), .preset_i(hi_pre), .count_o(cnt_h), .carry_n_o(cy_h), .borrow_n_o(bw_h));

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural reference: input histories, one model count per sequence length
  int    hu[$], hd[$], hl[$], hc[$];
  int    m_cnt[2];
  int    m_cy[2];
  int    m_bw[2];
  string m_tag[2];
  int    m_top[2] = '{9, 15};
  bit    m_ok = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hu = '{1, 1, 1}; hd = '{1, 1, 1}; hl = '{1, 1, 1}; hc = '{0, 0, 0};
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_cy[k] = 1; m_bw[k] = 1; m_tag[k] = "R8";
      end
      m_ok = 1'b0;
    end else begin
      int s;
      bit ru, rd;
      hu.push_back(int'(up)); hd.push_back(int'(dn));
      hl.push_back(int'(ld_n)); hc.push_back(int'(clr));
      s  = hu.size();
      ru = (hu[s-3] == 1) && (hu[s-4] == 0);
      rd = (hd[s-3] == 1) && (hd[s-4] == 0);
      for (int k = 0; k < 2; k++) begin
        if (hc[s-3] == 1) begin
          m_cnt[k] = 0; m_tag[k] = "R4";
        end else if (hl[s-3] == 0) begin
          m_cnt[k] = int'(pre); m_tag[k] = "R5";
        end else if (ru && rd) begin
          m_tag[k] = "R10";
          if (k == 0) $display("NOTE protocol violation: simultaneous up and down edges at %0t", $time);
        end else if (ru) begin
          m_tag[k] = (m_cnt[k] > m_top[k]) ? "R11" : (m_cnt[k] == m_top[k]) ? "R3" : "R1";
          m_cnt[k] = (m_cnt[k] >= m_top[k]) ? 0 : m_cnt[k] + 1;
        end else if (rd) begin
          m_tag[k] = (m_cnt[k] == 0) ? "R3" : (m_cnt[k] > m_top[k]) ? "R11" : "R2";
          m_cnt[k] = (m_cnt[k] == 0) ? m_top[k] : m_cnt[k] - 1;
        end else begin
          m_tag[k] = "R8";
        end
        m_cy[k] = (m_cnt[k] == m_top[k] && hu[s-2] == 0) ? 0 : 1;
        m_bw[k] = (m_cnt[k] == 0 && hd[s-2] == 0) ? 0 : 1;
      end
      while (hu.size() > 4) begin
        void'(hu.pop_front()); void'(hd.pop_front());
        void'(hl.pop_front()); void'(hc.pop_front());
      end
      m_ok = 1'b1;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_ok) begin
      cmp(m_tag[0], "decade count", int'(cnt_d), m_cnt[0]);
      cmp("R6", "decade carry", int'(cy_d), m_cy[0]);
      cmp("R7", "decade borrow", int'(bw_d), m_bw[0]);
      cmp(m_tag[1], "binary count", int'(cnt_b), m_cnt[1]);
      cmp("R6", "binary carry", int'(cy_b), m_cy[1]);
      cmp("R7", "binary borrow", int'(bw_b), m_bw[1]);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up(int n);
    for (int i = 0; i < n; i++) begin
      up = 1'b0; cyc(4); up = 1'b1; cyc(4);
    end
  endtask

  task automatic pulse_dn(int n);
    for (int i = 0; i < n; i++) begin
      dn = 1'b0; cyc(4); dn = 1'b1; cyc(4);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R8 reset state
    cmp("R8", "reset count", int'(cnt_d), 0);
    cmp("R8", "reset carry", int'(cy_d), 1);
    cmp("R8", "reset borrow", int'(bw_d), 1);

    // R1 / R3 counting up through the wrap
    pulse_up(12);
    cmp("R1", "binary after 12 up", int'(cnt_b), 12);
    cmp("R3", "decade after 12 up", int'(cnt_d), 2);

    // R2 / R3 counting down through zero
    pulse_dn(3);
    cmp("R2", "binary after 3 down", int'(cnt_b), 9);
    cmp("R3", "decade wrap down", int'(cnt_d), 9);

    // R6 carry echoes the low phase of the up strobe at the top value
    up = 1'b0; cyc(4);
    cmp("R6", "decade carry low", int'(cy_d), 0);
    cmp("R6", "binary carry high", int'(cy_b), 1);
    up = 1'b1; cyc(4);
    cmp("R6", "decade carry back high", int'(cy_d), 1);
    cmp("R3", "decade wrap up", int'(cnt_d), 0);

    // R7 borrow echoes the low phase of the down strobe at zero
    dn = 1'b0; cyc(4);
    cmp("R7", "decade borrow low", int'(bw_d), 0);
    cmp("R7", "binary borrow high", int'(bw_b), 1);
    dn = 1'b1; cyc(4);
    cmp("R7", "decade borrow back high", int'(bw_d), 1);

    // R8 hold while idle
    cyc(10);
    cmp("R8", "decade hold", int'(cnt_d), 9);

    // R5 load overrides strobes
    pre = 4'd12; ld_n = 1'b0; cyc(3);
    pulse_up(2);
    cmp("R5", "decade during load", int'(cnt_d), 12);
    ld_n = 1'b1; cyc(4);
    cmp("R5", "binary after load", int'(cnt_b), 12);

    // R11 out-of-range decade value
    pulse_up(1);
    cmp("R11", "decade 12 up", int'(cnt_d), 0);
    ld_n = 1'b0; cyc(4); ld_n = 1'b1; cyc(4);
    pulse_dn(3);
    cmp("R11", "decade 12 down 3", int'(cnt_d), 9);

    // R4 clear overrides load and strobes
    pre = 4'd5; ld_n = 1'b0; clr = 1'b1; cyc(2);
    pulse_up(1);
    cmp("R4", "decade under clear", int'(cnt_d), 0);
    cmp("R4", "binary under clear", int'(cnt_b), 0);
    clr = 1'b0; ld_n = 1'b1; cyc(4);

    // R9 strobe held low through a load, counted after release
    up = 1'b0; cyc(2);
    pre = 4'd3; ld_n = 1'b0; cyc(4);
    ld_n = 1'b1; cyc(4);
    cmp("R9", "decade after load", int'(cnt_d), 3);
    up = 1'b1; cyc(4);
    cmp("R9", "decade edge after load", int'(cnt_d), 4);

    // R10 simultaneous edges hold
    up = 1'b0; dn = 1'b0; cyc(4);
    up = 1'b1; dn = 1'b1; cyc(4);
    cmp("R10", "decade both edges", int'(cnt_d), 4);
    cmp("R10", "binary both edges", int'(cnt_b), 4);

    // R12 two-digit cascade
    clr = 1'b1; cyc(4); clr = 1'b0; cyc(4);
    pulse_up(25); cyc(6);
    cmp("R12", "cascade low digit up", int'(cnt_d), 5);
    cmp("R12", "cascade high digit up", int'(cnt_h), 2);
    pulse_dn(7); cyc(6);
    cmp("R12", "cascade low digit down", int'(cnt_d), 8);
    cmp("R12", "cascade high digit down", int'(cnt_h), 1);
    cmp("R12", "cascade high carry idle", int'(cy_h), 1);
    cmp("R12", "cascade high borrow idle", int'(bw_h), 1);

    summary();
    $finish;
  end
endmodule